// File: doc/BRIEF.md
# Program Counter Sequencer

This block holds the 15-bit program address of a small 8-bit microcontroller core and chooses its next value once per instruction cycle. An instruction cycle spans four system clock cycles, produced by an internal 2-bit phase counter; the address register moves only at the edge that closes phase 3. The candidates for the next address are the sequential increment, a bank-confined skip over the next instruction, a short jump that replaces the low address byte, a jump or call built from two bank bits and a 13-bit instruction field, a return that loads the stack top, and three fixed interrupt vectors spaced four words apart.

The decoder drives the control strobes for the instruction now executing and holds them through its instruction cycle. The address output is the address of the instruction being executed. Any change of control flow raises a flush flag for the whole next instruction cycle. The fetch pipeline uses this flag to throw away its prefetched word and run a dummy cycle instead. For calls and accepted interrupts, the block offers the return address and a push strobe to the external stack. For returns, it issues a pop strobe.

Top module: `pcs_top`

## Requirements
- R1: While rst_ni is low, and after it rises until the first update, pc_o is 0x0000, phase_o is 0 and flush_o is 0.
- R2: phase_o steps 0,1,2,3 and then back to 0, once per clock. pc_o and flush_o change only at the clock edge that ends phase 3. Strobes are sampled at that edge.
- R3: With no accepted request, the next pc_o is pc_o+1 modulo 2^15 and flush_o is 0 in the next instruction cycle.
- R4: An accepted skip_i loads {pc_o[14:13], (pc_o[12:0]+2) mod 2^13}. The skip never leaves the current 8K-word bank.
- R5: An accepted pcl_wr_i loads {pc_o[14:8], pcl_data_i}.
- R6: An accepted jmp_i or call_i loads {bank_i, addr_field_i}. An accepted call_i also raises push_o during phase 3, with push_data_o = pc_o+1 modulo 2^15.
- R7: An accepted ret_i loads stack_top_i and raises pop_o during phase 3. push_o and pop_o are never high together.
- R8: ext_irq_i loads 0x0004, tmr0_irq_i loads 0x0008 and tmr1_irq_i loads 0x000C, with priority in that order. Every accepted interrupt raises push_o with push_data_o = pc_o+1.
- R9: When requests coincide, the priority is: interrupts, then ret_i, then jmp_i/call_i, then pcl_wr_i, then skip_i, then increment.
- R10: Each accepted request of R4 to R8 sets flush_o for exactly the following instruction cycle. While flush_o is 1, the strobes skip_i, pcl_wr_i, jmp_i, call_i and ret_i are ignored: the address increments and no push or pop is issued. Interrupts are still accepted while flush_o is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| ext_irq_i | input | 1 | External interrupt request |
| tmr0_irq_i | input | 1 | Timer 0 overflow request |
| tmr1_irq_i | input | 1 | Timer 1 overflow request |
| ret_i | input | 1 | Return from subroutine or interrupt |
| jmp_i | input | 1 | Jump |
| call_i | input | 1 | Subroutine call |
| pcl_wr_i | input | 1 | Write to low address byte |
| pcl_data_i | input | 8 | Data for low-byte write |
| skip_i | input | 1 | Skip condition met |
| bank_i | input | 2 | Bank-select bits for jump/call |
| addr_field_i | input | 13 | Instruction address field |
| stack_top_i | input | 15 | Top of return stack |
| pc_o | output | 15 | Address of current instruction |
| phase_o | output | 2 | System-clock phase within instruction cycle |
| flush_o | output | 1 | Dummy cycle: discard prefetched word |
| push_o | output | 1 | Push return address |
| push_data_o | output | 15 | Return address to push |
| pop_o | output | 1 | Pop stack |

## Verification
The bench targets the bank boundary of the skip. A skip from 0x1FFF or 0x7FFE must stay in its bank, so a design that carries into bit 13 would leave the bank. It also runs the increment across 0x7FFF, where a wider adder would produce a stray bit. It offers every strobe while flush_o is set: a design that forgot to block them would jump during the dummy cycle, or push and pop without cause. Coinciding requests in all pairs are checked against the fixed priority, and so are the pushed return address and the exact four-clock length of flush_o, so a reordered priority, an off-by-one return address or a flag that stays high too long would show up as wrong addresses or strobes.

// File: rtl/pcs_pkg.sv
package pcs_pkg;
  localparam int unsigned PC_W   = 15;
  localparam int unsigned BANK_W = 2;
  localparam int unsigned OFS_W  = PC_W - BANK_W;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned PH_W   = 2;

  typedef logic [PC_W-1:0] pc_t;

  typedef enum logic [2:0] {
    SRC_INC, SRC_SKIP, SRC_PCL, SRC_JMP, SRC_RET, SRC_VEC
  } src_e;

  localparam pc_t VEC_EXT  = pc_t'(4);
  localparam pc_t VEC_TMR0 = pc_t'(8);
  localparam pc_t VEC_TMR1 = pc_t'(12);
endpackage

// File: rtl/pcs_phase.sv
module pcs_phase #(
  parameter int unsigned PH_W = 2
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  output logic [PH_W-1:0] phase_o,
  output logic            last_o
);
  logic [PH_W-1:0] ph_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ph_q <= '0;
    else         ph_q <= ph_q + 1'b1;
  end

  assign phase_o = ph_q;
  assign last_o  = &ph_q;

  a_r2_phase_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ph_q == PH_W'($past(ph_q) + 1'b1));
endmodule

// File: rtl/pcs_next.sv
module pcs_next
  import pcs_pkg::*;
(
  input  pc_t               pc_i,
  input  logic              flush_i,
  input  logic              ext_irq_i,
  input  logic              tmr0_irq_i,
  input  logic              tmr1_irq_i,
  input  logic              ret_i,
  input  logic              jmp_i,
  input  logic              call_i,
  input  logic              pcl_wr_i,
  input  logic [BYTE_W-1:0] pcl_data_i,
  input  logic              skip_i,
  input  logic [BANK_W-1:0] bank_i,
  input  logic [OFS_W-1:0]  addr_field_i,
  input  pc_t               stack_top_i,
  output pc_t               nxt_pc_o,
  output logic              xfer_o,
  output logic              push_o,
  output logic              pop_o
);
  logic irq;
  logic live;
  src_e src;
  pc_t  vec;
  logic [OFS_W-1:0] skip_ofs;

  assign irq  = ext_irq_i | tmr0_irq_i | tmr1_irq_i;
  assign live = ~flush_i;  // dummy slot executes nothing

  always_comb begin
    if (ext_irq_i)       vec = VEC_EXT;
    else if (tmr0_irq_i) vec = VEC_TMR0;
    else                 vec = VEC_TMR1;
  end

  always_comb begin
    if (irq)                          src = SRC_VEC;
    else if (live && ret_i)           src = SRC_RET;
    else if (live && (jmp_i|call_i))  src = SRC_JMP;
    else if (live && pcl_wr_i)        src = SRC_PCL;
    else if (live && skip_i)          src = SRC_SKIP;
    else                              src = SRC_INC;
  end

  assign skip_ofs = pc_i[OFS_W-1:0] + OFS_W'(2);

  always_comb begin
    unique case (src)
      SRC_VEC:  nxt_pc_o = vec;
      SRC_RET:  nxt_pc_o = stack_top_i;
      SRC_JMP:  nxt_pc_o = {bank_i, addr_field_i};
      SRC_PCL:  nxt_pc_o = {pc_i[PC_W-1:BYTE_W], pcl_data_i};
      SRC_SKIP: nxt_pc_o = {pc_i[PC_W-1:OFS_W], skip_ofs};
      default:  nxt_pc_o = pc_i + pc_t'(1);
    endcase
  end

  assign xfer_o = (src != SRC_INC);
  assign push_o = (src == SRC_VEC) || (src == SRC_JMP && call_i);
  assign pop_o  = (src == SRC_RET);

  always_comb begin
    a_r7_push_pop_excl: assert (!(push_o && pop_o));
    a_r10_flush_blocks: assert (!(flush_i && !irq && xfer_o));
  end
endmodule

// File: rtl/pcs_top.sv
module pcs_top
  import pcs_pkg::*;
(
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  ext_irq_i,
  input  logic                  tmr0_irq_i,
  input  logic                  tmr1_irq_i,
  input  logic                  ret_i,
  input  logic                  jmp_i,
  input  logic                  call_i,
  input  logic                  pcl_wr_i,
  input  logic [BYTE_W-1:0]     pcl_data_i,
  input  logic                  skip_i,
  input  logic [BANK_W-1:0]     bank_i,
  input  logic [OFS_W-1:0]      addr_field_i,
  input  logic [PC_W-1:0]       stack_top_i,
  output logic [PC_W-1:0]       pc_o,
  output logic [PH_W-1:0]       phase_o,
  output logic                  flush_o,
  output logic                  push_o,
  output logic [PC_W-1:0]       push_data_o,
  output logic                  pop_o
);
  pc_t  pc_q, nxt_pc;
  logic flush_q, last, xfer, push_sel, pop_sel;

  pcs_phase #(.PH_W(PH_W)) u_phase (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .phase_o (phase_o),
    .last_o  (last)
  );

  pcs_next u_next (
    .pc_i         (pc_q),
    .flush_i      (flush_q),
    .ext_irq_i    (ext_irq_i),
    .tmr0_irq_i   (tmr0_irq_i),
    .tmr1_irq_i   (tmr1_irq_i),
    .ret_i        (ret_i),
    .jmp_i        (jmp_i),
    .call_i       (call_i),
    .pcl_wr_i     (pcl_wr_i),
    .pcl_data_i   (pcl_data_i),
    .skip_i       (skip_i),
    .bank_i       (bank_i),
    .addr_field_i (addr_field_i),
    .stack_top_i  (stack_top_i),
    .nxt_pc_o     (nxt_pc),
    .xfer_o       (xfer),
    .push_o       (push_sel),
    .pop_o        (pop_sel)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pc_q    <= '0;
      flush_q <= 1'b0;
    end else if (last) begin
      pc_q    <= nxt_pc;
      flush_q <= xfer;
    end
  end

  assign pc_o        = pc_q;
  assign flush_o     = flush_q;
  assign push_o      = last & push_sel;
  assign pop_o       = last & pop_sel;
  assign push_data_o = pc_q + pc_t'(1);

  a_r2_pc_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !last |=> $stable(pc_q) && $stable(flush_q));
  a_r10_flush_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    last && xfer |=> flush_q);
  a_r8_ext_vec: assert property (@(posedge clk_i) disable iff (!rst_ni)
    last && ext_irq_i |=> pc_q == VEC_EXT);
  a_r3_inc: assert property (@(posedge clk_i) disable iff (!rst_ni)
    last && !xfer |=> pc_q == pc_t'($past(pc_q) + 1'b1) && !flush_q);
  a_r4_skip_bank: assert property (@(posedge clk_i) disable iff (!rst_ni)
    last && skip_i && !flush_q && !ext_irq_i && !tmr0_irq_i && !tmr1_irq_i &&
    !ret_i && !jmp_i && !call_i && !pcl_wr_i
    |=> pc_q[PC_W-1:OFS_W] == $past(pc_q[PC_W-1:OFS_W]));
endmodule

// File: tb/pcs_top_tb_top.sv
module pcs_top_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic e, t0, t1, rt, jp, cl, pw, sk;
  logic [7:0]  pd;
  logic [1:0]  bk;
  logic [12:0] af;
  logic [14:0] st;
  logic [14:0] pc;
  logic [1:0]  ph;
  logic fl, pu, po;
  logic [14:0] pud;

  int checks = 0;
  int fails  = 0;
  logic [14:0] m_pc = '0;
  logic        m_fl = 1'b0;

  always #10 clk = ~clk;

  pcs_top dut_i (
    .clk_i(clk), .rst_ni(rst_n), .ext_irq_i(e), .tmr0_irq_i(t0), .tmr1_irq_i(t1),
    .ret_i(rt), .jmp_i(jp), .call_i(cl), .pcl_wr_i(pw), .pcl_data_i(pd),
    .skip_i(sk), .bank_i(bk), .addr_field_i(af), .stack_top_i(st),
    .pc_o(pc), .phase_o(ph), .flush_o(fl), .push_o(pu), .push_data_o(pud), .pop_o(po)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  // req bits: [7]ext [6]t0 [5]t1 [4]ret [3]jmp [2]call [1]pcl [0]skip
  task automatic instr(input string req, input logic [7:0] r, input logic [7:0] d,
                       input logic [1:0] b, input logic [12:0] f, input logic [14:0] s);
    logic irq, live, x_push, x_pop;
    logic [14:0] nx;
    {e, t0, t1, rt, jp, cl, pw, sk} = r;
    pd = d; bk = b; af = f; st = s;
    irq  = r[7] | r[6] | r[5];
    live = !m_fl;
    x_push = 1'b0; x_pop = 1'b0;
    if (r[7])                 begin nx = 15'h0004; x_push = 1'b1; end
    else if (r[6])            begin nx = 15'h0008; x_push = 1'b1; end
    else if (r[5])            begin nx = 15'h000C; x_push = 1'b1; end
    else if (live && r[4])    begin nx = s; x_pop = 1'b1; end
    else if (live && (r[3]|r[2])) begin nx = {b, f}; x_push = r[2]; end
    else if (live && r[1])    nx = {m_pc[14:8], d};
    else if (live && r[0])    nx = {m_pc[14:13], 13'(m_pc[12:0] + 13'd2)};
    else                      nx = 15'(m_pc + 15'd1);
    @(posedge clk); @(negedge clk);
    chk({req, "/R2 hold"}, {17'd0, pc}, {17'd0, m_pc});
    @(posedge clk); @(posedge clk); @(negedge clk);
    chk({req, "/R2 phase"}, {30'd0, ph}, 32'd3);
    chk({req, "/push"}, {31'd0, pu}, {31'd0, x_push});
    chk({req, "/pop"}, {31'd0, po}, {31'd0, x_pop});
    if (x_push) chk({req, "/R6 push data"}, {17'd0, pud}, {17'd0, 15'(m_pc + 15'd1)});
    @(posedge clk); @(negedge clk);
    m_fl = (nx != 15'(m_pc + 15'd1)) || irq || x_pop || x_push ||
           (live && (r[3] | r[1] | r[0]));
    if (!irq && !live) m_fl = 1'b0;
    m_pc = nx;
    chk({req, "/pc"}, {17'd0, pc}, {17'd0, m_pc});
    chk({req, "/R10 flush"}, {31'd0, fl}, {31'd0, m_fl});
    {e, t0, t1, rt, jp, cl, pw, sk} = '0;
  endtask

  initial begin
    {e, t0, t1, rt, jp, cl, pw, sk} = '0;
    pd = '0; bk = '0; af = '0; st = '0;
    #5;
    chk("R1 pc", {17'd0, pc}, 0);
    chk("R1 flush", {31'd0, fl}, 0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    chk("R1 phase", {30'd0, ph}, 0);
    chk("R1 pc rel", {17'd0, pc}, 0);
    // R3 increments
    for (int i = 0; i < 20; i++) instr("R3", 8'h00, 0, 0, 0, 0);
    // R6 jump sweep over banks and fields, each followed by increments
    for (int b = 0; b < 4; b++)
      for (int k = 0; k < 8; k++) begin
        instr("R6 jmp", 8'h08, 0, 2'(b), 13'(k * 1171 + 5), 0);
        instr("R10 dummy", 8'h00, 0, 0, 0, 0);
      end
    // R3 wrap
    instr("R6 jmp", 8'h08, 0, 2'd3, 13'h1FFE, 0);
    instr("R3", 8'h00, 0, 0, 0, 0);
    instr("R3 wrap", 8'h00, 0, 0, 0, 0);
    // R4 skip at bank edges
    for (int b = 0; b < 4; b++)
      for (int o = 0; o < 4; o++) begin
        instr("R6 jmp", 8'h08, 0, 2'(b), 13'(13'h1FFC + o), 0);
        instr("R3", 8'h00, 0, 0, 0, 0);
        instr("R4 skip", 8'h01, 0, 0, 0, 0);
        instr("R3", 8'h00, 0, 0, 0, 0);
      end
    // R5 pcl sweep
    for (int d = 0; d < 256; d += 17) begin
      instr("R5 pcl", 8'h02, 8'(d), 0, 0, 0);
      instr("R3", 8'h00, 0, 0, 0, 0);
    end
    // R6 call, R7 return
    for (int k = 0; k < 6; k++) begin
      instr("R6 call", 8'h04, 0, 2'(k), 13'(k * 901), 0);
      instr("R3", 8'h00, 0, 0, 0, 0);
      instr("R7 ret", 8'h10, 0, 0, 0, 15'(k * 4999 + 3));
      instr("R3", 8'h00, 0, 0, 0, 0);
    end
    // R8 vectors and their priority
    for (int v = 1; v < 8; v++) begin
      instr("R8 vec", 8'(v << 5), 0, 0, 0, 0);
      instr("R3", 8'h00, 0, 0, 0, 0);
    end
    // R9 all request combinations, from a non-flushed state
    for (int r = 1; r < 256; r++) begin
      instr("R3", 8'h00, 0, 0, 0, 0);
      instr("R9 prio", 8'(r), 8'(r * 7), 2'(r), 13'(r * 29), 15'(r * 113));
      // R10 ignored strobes during dummy, interrupts accepted
      instr("R10 blocked", 8'(r & 8'h1F), 8'hA5, 2'd2, 13'h0ABC, 15'h1234);
    end
    instr("R3", 8'h00, 0, 0, 0, 0);
    instr("R10 irq in dummy", 8'h08, 0, 2'd1, 13'h0100, 0);
    instr("R10 irq in dummy", 8'h40, 0, 0, 0, 0);
    instr("R3", 8'h00, 0, 0, 0, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog act=1 exp=0");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule